// File: doc/BRIEF.md
# Eight-Channel Threshold Monitor Bank

The block watches eight measurement channels. Each enabled channel fetches a ready-made 16-bit code from a sample source at a chosen rate. The block then checks that code against a lower and an upper limit set by software. A code under the lower limit latches a per-channel "low" flag, and a code over the upper limit latches a "high" flag. The flags feed one level interrupt through per-channel masks.

Software uses a byte-wide register port. Every channel owns a group of eight bytes. The group holds the source selector, both limits, the interval choice, a control byte and the enable bits. Global bytes hold the run enable, a one-shot conversion trigger and the three interval timer codes. Samples come in over a request/valid handshake. The block keeps one request open at a time. When several channels are due together, they are served from the lowest index upward.

Top module: `thr_mon_bank`

## Requirements
- R1: After reset the low-flag byte (0x0a), the high-flag byte (0x0b) and the run byte (0x46) read 0x00, and `irq` and `smp_req` are low. Offset 0x0f reads 8, offset 0x44 reads 0x03 and offset 0x45 reads 0xA4 (upper nibble timer B = 10, lower nibble timer C = 4).
- R2: Channel n's group starts at 0x60 + 8·n. Its bytes hold, in address order: source selector, lower limit bits 7:0, lower limit bits 15:8, upper limit bits 7:0, upper limit bits 15:8, interval code (bits 1:0), control (settle delay bits 3:0, calibration select bits 5:4), enable. Every byte reads back what was written, and `smp_sel` carries the selector of the channel being sampled.
- R3: In the enable byte, bit 7 turns on measurement, bit 1 unmasks the high flag and bit 0 unmasks the low flag. A channel with bit 7 clear is never requested.
- R4: A returned code strictly below the lower limit sets bit n of 0x0a. A code strictly above the upper limit sets bit n of 0x0b. A code equal to a limit sets neither bit.
- R5: The flags stay set through later in-range samples and are cleared only by a write to any byte of that channel's group.
- R6: `irq` is high exactly when some measuring channel has a set low flag with bit 0 enabled, or a set high flag with bit 1 enabled.
- R7: Once raised, `smp_req` holds with a stable `smp_chan` and `smp_sel` until `smp_valid` is seen. Only one request is open at a time.
- R8: Channels due in the same cycle are requested in ascending channel order.
- R9: Bit 7 of 0x46 is the run enable. While it is clear, no request starts, due work is dropped and the interval timers are held.
- R10: Writing 1 to bit 7 of 0x47 while running queues one sample for every measuring channel, whatever its interval code. Offset 0x47 reads 0.
- R11: Interval codes 0, 1 and 2 pick timers A (0x44 bits 3:0), B and C. A timer with code c fires every (c+1)·UNIT_CYCLES cycles. Code 3 means no periodic sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| smp_req | output | 1 | Sample request pending |
| smp_chan | output | 3 | Channel index of the open request |
| smp_sel | output | 8 | Source selector of the open request |
| smp_valid | input | 1 | Sample code valid, completes the request |
| smp_code | input | 16 | Returned sample code |
| irq | output | 1 | Level interrupt |

## Verification
The first sweep triggers all eight channels at once with codes below, equal to, and above each limit. This separates strict comparison from inclusive comparison and exposes any deviation from ascending service order. A single masked channel then receives an over-limit code followed by an in-range code. That sequence distinguishes sticky flags from level flags and masked flags from unmasked ones. A later write to one limit byte shows that a write clears the flags. Two channels on different timers are counted over a fixed window to tell the timer periods apart. Interval code 3 and a cleared run bit must yield zero requests. A cycle-by-cycle model of the flags predicts `irq` on every clock.

// File: rtl/thr_mon_pkg.sv
package thr_mon_pkg;
    localparam int NCH  = 8;
    localparam int CW   = $clog2(NCH);
    localparam int TW   = 4;
    localparam int NTMR = 3;

    localparam logic [7:0] A_STLO   = 8'h0A;
    localparam logic [7:0] A_STHI   = 8'h0B;
    localparam logic [7:0] A_NCH    = 8'h0F;
    localparam logic [7:0] A_TMRA   = 8'h44;
    localparam logic [7:0] A_TMRBC  = 8'h45;
    localparam logic [7:0] A_RUN    = 8'h46;
    localparam logic [7:0] A_CONV   = 8'h47;
    localparam logic [7:0] A_CHBASE = 8'h60;
    localparam logic [7:0] A_CHEND  = 8'(A_CHBASE + 8 * NCH);

    localparam logic [1:0] ISEL_NONE = 2'd3;

    typedef enum logic [2:0] {
        B_SEL, B_LO0, B_LO1, B_HI0, B_HI1, B_IVL, B_CTL, B_EN
    } ch_byte_e;

    typedef struct packed {
        logic [7:0]  sel;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [1:0]  isel;
        logic [7:0]  ctl;
        logic        meas;
        logic        hi_ie;
        logic        lo_ie;
    } ch_cfg_t;

    localparam ch_cfg_t CFG_RST = '{sel: 8'h00, lo: 16'h0000, hi: 16'hFFFF,
                                   isel: ISEL_NONE, ctl: 8'h00,
                                   meas: 1'b0, hi_ie: 1'b0, lo_ie: 1'b0};

    function automatic logic in_chan(input logic [7:0] a);
        return (a >= A_CHBASE) && (a < A_CHEND);
    endfunction

    function automatic logic [CW-1:0] chan_of(input logic [7:0] a);
        logic [7:0] off;
        off = a - A_CHBASE;
        return off[CW+2:3];
    endfunction

    function automatic logic [CW-1:0] lowest(input logic [NCH-1:0] v);
        logic [CW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (v[i]) r = CW'(i);
        return r;
    endfunction
endpackage

// File: rtl/thr_mon_timers.sv
module thr_mon_timers
    import thr_mon_pkg::*;
#(
    parameter int UNIT_CYCLES = 50000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      run,
    input  logic [NTMR-1:0][TW-1:0]   code,
    output logic [NTMR-1:0]           fire
);
    localparam int PW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

    logic [PW-1:0] pre;
    logic          unit;

    assign unit = run && (pre == PW'(UNIT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || unit) pre <= '0;
        else                     pre <= pre + 1'b1;
    end

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        logic [TW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || !run)  cnt <= '0;
            else if (unit)    cnt <= (cnt >= code[k]) ? '0 : cnt + 1'b1;
        end
        assign fire[k] = unit && (cnt >= code[k]);
    end
endmodule

// File: rtl/thr_mon_arb.sv
module thr_mon_arb
    import thr_mon_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [NCH-1:0] due,
    input  logic           done,
    output logic           busy,
    output logic [CW-1:0]  cur
);
    logic [NCH-1:0] pend;
    logic [NCH-1:0] grant;
    logic           start;

    assign start = run && !busy && (|pend);
    assign grant = start ? (NCH'(1) << lowest(pend)) : '0;

    always_ff @(posedge clk) begin
        if (rst || !run) pend <= '0;
        else             pend <= (pend | due) & ~grant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cur  <= lowest(pend);
        end else if (busy && done) begin
            busy <= 1'b0;
        end
    end

    // A completed request closes before any new one opens.
    p_single_open_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);
endmodule

// File: rtl/thr_mon_bank.sv
module thr_mon_bank
    import thr_mon_pkg::*;
#(
    parameter int UNIT_CYCLES = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        smp_req,
    output logic [2:0]  smp_chan,
    output logic [7:0]  smp_sel,
    input  logic        smp_valid,
    input  logic [15:0] smp_code,
    output logic        irq
);
    ch_cfg_t                    cfg [NCH];
    logic [NTMR-1:0][TW-1:0]    tcode;
    logic                       run;
    logic [NCH-1:0]             st_lo, st_hi, due;
    logic [NTMR-1:0]            fire;
    logic                       busy;
    logic [CW-1:0]              cur;
    logic                       conv_pulse;
    logic                       chan_wr;
    logic [CW-1:0]              wch;

    assign chan_wr    = wr_en && in_chan(addr);
    assign wch        = chan_of(addr);
    assign conv_pulse = wr_en && (addr == A_CONV) && wdata[7] && run;

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NCH; n++) cfg[n] <= CFG_RST;
            tcode[0] <= 4'd3;
            tcode[1] <= 4'd10;
            tcode[2] <= 4'd4;
            run      <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_TMRA:  tcode[0] <= wdata[3:0];
                A_TMRBC: begin
                    tcode[1] <= wdata[7:4];
                    tcode[2] <= wdata[3:0];
                end
                A_RUN:   run <= wdata[7];
                default: if (in_chan(addr)) begin
                    case (ch_byte_e'(addr[2:0]))
                        B_SEL: cfg[wch].sel      <= wdata;
                        B_LO0: cfg[wch].lo[7:0]  <= wdata;
                        B_LO1: cfg[wch].lo[15:8] <= wdata;
                        B_HI0: cfg[wch].hi[7:0]  <= wdata;
                        B_HI1: cfg[wch].hi[15:8] <= wdata;
                        B_IVL: cfg[wch].isel     <= wdata[1:0];
                        B_CTL: cfg[wch].ctl      <= {2'b00, wdata[5:0]};
                        B_EN:  begin
                            cfg[wch].meas  <= wdata[7];
                            cfg[wch].hi_ie <= wdata[1];
                            cfg[wch].lo_ie <= wdata[0];
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // Due generation from timers and one-shot trigger
    always_comb begin
        logic [3:0] fx;
        fx = {1'b0, fire};
        for (int n = 0; n < NCH; n++)
            due[n] = run && cfg[n].meas &&
                     (conv_pulse || (cfg[n].isel != ISEL_NONE && fx[cfg[n].isel]));
    end

    thr_mon_timers #(.UNIT_CYCLES(UNIT_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .run(run), .code(tcode), .fire(fire)
    );

    thr_mon_arb u_arb (
        .clk(clk), .rst(rst), .run(run), .due(due), .done(smp_valid),
        .busy(busy), .cur(cur)
    );

    assign smp_req  = busy;
    assign smp_chan = 3'(cur);
    assign smp_sel  = cfg[cur].sel;

    // Sticky crossing flags
    always_ff @(posedge clk) begin
        if (rst) begin
            st_lo <= '0;
            st_hi <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (chan_wr && wch == CW'(n)) begin
                    st_lo[n] <= 1'b0;
                    st_hi[n] <= 1'b0;
                end else if (busy && smp_valid && cur == CW'(n) && cfg[n].meas) begin
                    if (smp_code < cfg[n].lo) st_lo[n] <= 1'b1;
                    if (smp_code > cfg[n].hi) st_hi[n] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic [NCH-1:0] act;
        for (int n = 0; n < NCH; n++)
            act[n] = cfg[n].meas && ((st_lo[n] && cfg[n].lo_ie) || (st_hi[n] && cfg[n].hi_ie));
        irq = |act;
    end

    // Read mux
    always_comb begin
        ch_cfg_t rc;
        rc    = cfg[wch];
        rdata = 8'h00;
        case (addr)
            A_STLO:  rdata = st_lo;
            A_STHI:  rdata = st_hi;
            A_NCH:   rdata = 8'(NCH);
            A_TMRA:  rdata = {4'h0, tcode[0]};
            A_TMRBC: rdata = {tcode[1], tcode[2]};
            A_RUN:   rdata = {run, 7'b0};
            default: if (in_chan(addr)) begin
                case (ch_byte_e'(addr[2:0]))
                    B_SEL: rdata = rc.sel;
                    B_LO0: rdata = rc.lo[7:0];
                    B_LO1: rdata = rc.lo[15:8];
                    B_HI0: rdata = rc.hi[7:0];
                    B_HI1: rdata = rc.hi[15:8];
                    B_IVL: rdata = {6'b0, rc.isel};
                    B_CTL: rdata = rc.ctl;
                    B_EN:  rdata = {rc.meas, 5'b0, rc.hi_ie, rc.lo_ie};
                    default: rdata = 8'h00;
                endcase
            end
        endcase
    end

    // An open request keeps its channel until answered.
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_req && !smp_valid) |=> (smp_req && smp_chan == $past(smp_chan)));

    // Set flags survive every cycle without a write to a channel group.
    p_sticky_lo_r5: assert property (@(posedge clk) disable iff (rst)
        !chan_wr |=> ((st_lo & $past(st_lo)) == $past(st_lo)));
    p_sticky_hi_r5: assert property (@(posedge clk) disable iff (rst)
        !chan_wr |=> ((st_hi & $past(st_hi)) == $past(st_hi)));

    // No request starts while the run bit is clear.
    p_no_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !$rose(smp_req));
endmodule

// File: tb/thr_mon_bank_tb.sv
`timescale 1ns/1ps
module thr_mon_bank_tb;
    localparam int UNIT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        smp_req;
    logic [2:0]  smp_chan;
    logic [7:0]  smp_sel;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_code = 16'h0000;
    logic        irq;

    int checks = 0;
    int errs   = 0;

    thr_mon_bank #(.UNIT_CYCLES(UNIT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .smp_req(smp_req), .smp_chan(smp_chan), .smp_sel(smp_sel),
        .smp_valid(smp_valid), .smp_code(smp_code), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #5 d = rdata;
    endtask

    // ---------------- sample responder ----------------
    logic [15:0] code_tab [8];
    int          req_cnt  [8];
    logic [7:0]  last_sel [8];
    int          order_q  [$];
    int          hs_bad = 0;
    logic [2:0]  r_ch;
    logic [15:0] r_code;

    initial begin
        for (int i = 0; i < 8; i++) begin
            code_tab[i] = 16'h4000; req_cnt[i] = 0; last_sel[i] = 8'h00;
        end
        forever begin
            @(negedge clk);
            if (smp_req && !rst) begin
                logic [2:0] c;
                logic [7:0] s;
                c = smp_chan; s = smp_sel;
                order_q.push_back(int'(c));
                req_cnt[c]++;
                last_sel[c] = s;
                for (int w = 0; w < 2; w++) begin
                    @(negedge clk);
                    if (!smp_req || smp_chan != c || smp_sel != s) hs_bad++;
                end
                r_ch = c; r_code = code_tab[c];
                smp_code = code_tab[c];
                smp_valid = 1'b1;
                @(negedge clk);
                smp_valid = 1'b0;
            end
        end
    end

    // ---------------- reference flag model ----------------
    logic [15:0] m_lo [8];
    logic [15:0] m_hi [8];
    logic [7:0]  m_en [8];
    logic [7:0]  m_stlo, m_sthi;

    function automatic logic m_irq();
        logic r;
        r = 1'b0;
        for (int i = 0; i < 8; i++)
            if (m_en[i][7] && ((m_stlo[i] && m_en[i][0]) || (m_sthi[i] && m_en[i][1])))
                r = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_lo[i] = 16'h0000; m_hi[i] = 16'hFFFF; m_en[i] = 8'h00;
            end
            m_stlo = 8'h00; m_sthi = 8'h00;
        end else begin
            if (smp_valid && m_en[r_ch][7]) begin
                if (r_code < m_lo[r_ch]) m_stlo[r_ch] = 1'b1;
                if (r_code > m_hi[r_ch]) m_sthi[r_ch] = 1'b1;
            end
            if (wr_en && addr >= 8'h60 && addr < 8'hA0) begin
                int ch;
                ch = (int'(addr) - 'h60) / 8;
                m_stlo[ch] = 1'b0; m_sthi[ch] = 1'b0;
                case (addr[2:0])
                    3'd1: m_lo[ch][7:0]  = wdata;
                    3'd2: m_lo[ch][15:8] = wdata;
                    3'd3: m_hi[ch][7:0]  = wdata;
                    3'd4: m_hi[ch][15:8] = wdata;
                    3'd7: m_en[ch]       = wdata;
                    default: ;
                endcase
            end
        end
    end

    // irq compared against the model on every clock (R6)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (irq !== m_irq()) begin
                errs++;
                $display("FAIL R6 irq per-cycle: actual=%0b expected=%0b at %0t", irq, m_irq(), $time);
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] d;
        int tot;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h0A, d); chk("R1 low flags", d, 8'h00);
        rd(8'h0B, d); chk("R1 high flags", d, 8'h00);
        rd(8'h46, d); chk("R1 run byte", d, 8'h00);
        rd(8'h0F, d); chk("R1 channel count", d, 8);
        rd(8'h44, d); chk("R1 timer A code", d, 8'h03);
        rd(8'h45, d); chk("R1 timer B/C codes", d, 8'hA4);
        chk("R1 irq low", irq, 0);
        chk("R1 no request", smp_req, 0);

        // Configure all channels: lower 0x1000, upper 0x8000, code 3, all enables
        for (int n = 0; n < 8; n++) begin
            logic [7:0] b;
            b = 8'(8'h60 + 8 * n);
            wr(b + 0, 8'(8'h10 + n));
            wr(b + 1, 8'h00); wr(b + 2, 8'h10);
            wr(b + 3, 8'h00); wr(b + 4, 8'h80);
            wr(b + 5, 8'h03); wr(b + 6, 8'h25); wr(b + 7, 8'h83);
        end
        // R2 readback of channel 3 group
        rd(8'h78, d); chk("R2 ch3 selector", d, 8'h13);
        rd(8'h79, d); chk("R2 ch3 lower lsb", d, 8'h00);
        rd(8'h7A, d); chk("R2 ch3 lower msb", d, 8'h10);
        rd(8'h7B, d); chk("R2 ch3 upper lsb", d, 8'h00);
        rd(8'h7C, d); chk("R2 ch3 upper msb", d, 8'h80);
        rd(8'h7D, d); chk("R2 ch3 interval", d, 8'h03);
        rd(8'h7E, d); chk("R2 ch3 control", d, 8'h25);
        rd(8'h7F, d); chk("R3 ch3 enable byte", d, 8'h83);

        // R4 strict compare, R8 order, R10 one-shot
        code_tab[0] = 16'h0FFF; code_tab[1] = 16'h1000; code_tab[2] = 16'h8000;
        code_tab[3] = 16'h8001; code_tab[4] = 16'h0500; code_tab[5] = 16'h9000;
        code_tab[6] = 16'h4000; code_tab[7] = 16'h0000;
        wr(8'h46, 8'h80);
        rd(8'h46, d); chk("R9 run byte set", d, 8'h80);
        order_q.delete();
        wr(8'h47, 8'h80);
        repeat (80) @(negedge clk);
        chk("R10 one-shot request count", order_q.size(), 8);
        for (int i = 0; i < 8 && i < order_q.size(); i++)
            chk($sformatf("R8 order slot %0d", i), order_q[i], i);
        chk("R2 ch5 selector on smp_sel", last_sel[5], 8'h15);
        rd(8'h0A, d); chk("R4 low flags", d, 8'h91);
        rd(8'h0B, d); chk("R4 high flags", d, 8'h28);
        chk("R6 irq with unmasked flags", irq, 1);
        rd(8'h47, d); chk("R10 trigger reads zero", d, 8'h00);

        // R3/R6 masking: only ch3 measures, low mask only
        for (int n = 0; n < 8; n++)
            wr(8'(8'h67 + 8 * n), (n == 3) ? 8'h81 : 8'h00);
        order_q.delete();
        wr(8'h47, 8'h80);
        repeat (30) @(negedge clk);
        chk("R3 only measuring channel requested", order_q.size(), 1);
        if (order_q.size() > 0) chk("R3 requested channel", order_q[0], 3);
        rd(8'h0B, d); chk("R4 ch3 high flag", d, 8'h08);
        rd(8'h0A, d); chk("R5 low flags cleared by writes", d, 8'h00);
        chk("R6 masked high flag keeps irq low", irq, 0);

        // R5 sticky through in-range sample, cleared by write
        code_tab[3] = 16'h4000;
        wr(8'h47, 8'h80);
        repeat (30) @(negedge clk);
        rd(8'h0B, d); chk("R5 flag sticky after in-range", d, 8'h08);
        wr(8'h79, 8'h00);
        rd(8'h0B, d); chk("R5 flag cleared by group write", d, 8'h00);
        code_tab[3] = 16'h0500;
        wr(8'h47, 8'h80);
        repeat (30) @(negedge clk);
        rd(8'h0A, d); chk("R4 ch3 low flag", d, 8'h08);
        chk("R6 unmasked low flag raises irq", irq, 1);

        // R11 periodic timers: A code 1 (8 cycles), B code 2 (12 cycles)
        wr(8'h44, 8'h01);
        wr(8'h45, 8'h24);
        code_tab[2] = 16'h4000; code_tab[5] = 16'h4000;
        wr(8'h75, 8'h00); wr(8'h77, 8'h83);
        wr(8'h8D, 8'h01); wr(8'h8F, 8'h83);
        repeat (40) @(negedge clk);
        for (int i = 0; i < 8; i++) req_cnt[i] = 0;
        repeat (600) @(negedge clk);
        chk_rng("R11 timer A period", req_cnt[2], 73, 77);
        chk_rng("R11 timer B period", req_cnt[5], 48, 52);
        chk("R11 channel without timer", req_cnt[3], 0);

        wr(8'h75, 8'h03);
        repeat (30) @(negedge clk);
        for (int i = 0; i < 8; i++) req_cnt[i] = 0;
        repeat (200) @(negedge clk);
        chk("R11 interval code 3 stops sampling", req_cnt[2], 0);
        chk_rng("R11 timer B still running", req_cnt[5], 15, 18);

        // R9 run bit clear
        wr(8'h46, 8'h00);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 8; i++) req_cnt[i] = 0;
        wr(8'h47, 8'h80);
        repeat (200) @(negedge clk);
        tot = 0;
        for (int i = 0; i < 8; i++) tot += req_cnt[i];
        chk("R9 no requests while stopped", tot, 0);
        chk("R9 request line idle", smp_req, 0);

        chk("R7 handshake held stable", hs_bad, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule